// File: doc/BRIEF.md
# Quad Multiply Add/Subtract Sum Unit

This block is a DSP datapath. It takes four operand pairs and multiplies each pair. It then combines products 0 and 1 with an add or a subtract, and products 2 and 3 the same way. The two partial results are added to form one output. A operands are `AW` bits wide and B operands are `BW` bits wide. A product is `AW+BW` bits, each partial result is one bit wider, and the output is `AW+BW+2` bits. One control treats every operand as either two's complement or unsigned. Two further controls set the operation of each pair stage.

The datapath has three stages of optional registers: operand, product and result. A parameter enables or bypasses each stage. Every enabled stage takes its clock enable from one of four shared enable lines and its synchronous reset from one of four shared reset lines. A clock-select parameter is kept for each stage, and all three must resolve to the single `clk`. The operand registers can also act as two shift chains, one for A and one for B. This lets several units be cascaded through a serial input and a serial output per chain.

Top module: `quad_mac_sum`

## Requirements
- R1: With `signed_mode`=0, each operand is unsigned. `result` equals the exact value of (A0·B0 ± A1·B1) + (A2·B2 ± A3·B3), taken modulo 2^(AW+BW+2).
- R2: With `signed_mode`=1, each operand is two's complement. `result` is the exact signed value of the same expression in two's complement, `AW+BW+2` bits wide.
- R3: `sub0`=1 subtracts the lane 1 product from the lane 0 product, and `sub0`=0 adds them. `sub1` selects the same way between the lane 2 and lane 3 products.
- R4: Latency is the number of enabled stages, from 0 to 3 cycles. `signed_mode`, `sub0` and `sub1` move through the stages with their operands.
- R5: An enabled stage whose selected reset line is high at a clock edge clears to zero at that edge. Reset takes priority over enable.
- R6: An enabled stage whose selected enable line is low, and whose reset is low, holds its contents.
- R7: An enable or reset line that no enabled stage selects has no effect. A bypassed stage ignores every enable and reset line.
- R8: With `a_shift`=1 and the operand stage registered, lane 0 of A loads `a_sin` and lane k loads lane k-1. `a_sout` shows lane 3, so `a_sin` reaches `a_sout` after 4 enabled edges. `b_shift`, `b_sin` and `b_sout` behave the same way for B. With the operand stage bypassed, every lane and the serial output follow the serial input.
- R9: The output never wraps when every operand is all ones, unsigned, and both stages add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all stages |
| ce_src | input | 4 | Shared clock-enable lines |
| rst_src | input | 4 | Shared synchronous reset lines, active high |
| signed_mode | input | 1 | 1: two's-complement operands, 0: unsigned |
| sub0 | input | 1 | 1: lane0 − lane1, 0: lane0 + lane1 |
| sub1 | input | 1 | 1: lane2 − lane3, 0: lane2 + lane3 |
| a_shift | input | 1 | A lanes load from the shift chain instead of `a_bus` |
| b_shift | input | 1 | B lanes load from the shift chain instead of `b_bus` |
| a_bus | input | 4*AW | A operands, lane k at bits [k*AW +: AW] |
| b_bus | input | 4*BW | B operands, lane k at bits [k*BW +: BW] |
| a_sin | input | AW | A chain serial input |
| b_sin | input | BW | B chain serial input |
| a_sout | output | AW | A chain serial output (lane 3 operand) |
| b_sout | output | BW | B chain serial output (lane 3 operand) |
| result | output | AW+BW+2 | Final sum |

## Verification
The main function is driven with random operands across all four combinations of the two pair operations and both signedness modes. A mismatch there exposes a wrong sign extension or a swapped subtraction. Directed vectors use all-ones unsigned operands, signed minimum operands in subtraction, and zeros. These show whether the width growth is correct and separate signed wrap from unsigned wrap. A fully bypassed copy shares every input and is compared in the same cycle. This separates latency and control-alignment faults from arithmetic faults. Shift-chain sequences, held enables and reset pulses on selected and unselected lines show whether each stage follows its own lines.

// File: rtl/quad_mac_sum.sv
module quad_mac_sum #(
  parameter int AW      = 9,
  parameter int BW      = 9,
  parameter bit IN_REG  = 1'b1,
  parameter bit PL_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  parameter int IN_CLK  = 0,
  parameter int PL_CLK  = 0,
  parameter int OUT_CLK = 0,
  parameter int IN_CE   = 0,
  parameter int PL_CE   = 1,
  parameter int OUT_CE  = 2,
  parameter int IN_RST  = 1,
  parameter int PL_RST  = 2,
  parameter int OUT_RST = 3,
  localparam int PW = AW + BW,
  localparam int RW = PW + 2
) (
  input  logic            clk,
  input  logic [3:0]      ce_src,
  input  logic [3:0]      rst_src,
  input  logic            signed_mode,
  input  logic            sub0,
  input  logic            sub1,
  input  logic            a_shift,
  input  logic            b_shift,
  input  logic [4*AW-1:0] a_bus,
  input  logic [4*BW-1:0] b_bus,
  input  logic [AW-1:0]   a_sin,
  input  logic [BW-1:0]   b_sin,
  output logic [AW-1:0]   a_sout,
  output logic [BW-1:0]   b_sout,
  output logic [RW-1:0]   result
);

  localparam int CLK_SEL_SUM = IN_CLK + PL_CLK + OUT_CLK;

  function automatic logic [PW-1:0] mul(input logic [AW-1:0] a, input logic [BW-1:0] b,
                                        input logic sg);
    logic signed [AW:0]   ax;
    logic signed [BW:0]   bx;
    logic signed [PW+1:0] full;
    ax   = {sg & a[AW-1], a};
    bx   = {sg & b[BW-1], b};
    full = ax * bx;
    return full[PW-1:0];
  endfunction

  function automatic logic [PW:0] pair(input logic [PW-1:0] p, input logic [PW-1:0] q,
                                       input logic sg, input logic sub);
    logic [PW:0] px, qx;
    px = {sg & p[PW-1], p};
    qx = {sg & q[PW-1], q};
    return sub ? px - qx : px + qx;
  endfunction

  logic [3:0][AW-1:0] a_nx, a_op;
  logic [3:0][BW-1:0] b_nx, b_op;
  logic [2:0]         c_in, c_op;
  logic [3:0][PW-1:0] p_nx, p_op;
  logic [2:0]         c2_op;
  logic [PW:0]        s0, s1;
  logic [RW-1:0]      sum_d;
  logic               unused_lines;

  assign unused_lines = ^{ce_src, rst_src, CLK_SEL_SUM[0]};
  assign c_in = {signed_mode, sub0, sub1};

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [AW-1:0] a_ch;
    logic [BW-1:0] b_ch;
    if (k > 0 && IN_REG) begin : g_chain
      assign a_ch = a_op[k-1];
      assign b_ch = b_op[k-1];
    end else begin : g_head
      assign a_ch = a_sin;
      assign b_ch = b_sin;
    end
    assign a_nx[k] = a_shift ? a_ch : a_bus[k*AW +: AW];
    assign b_nx[k] = b_shift ? b_ch : b_bus[k*BW +: BW];
    assign p_nx[k] = mul(a_op[k], b_op[k], c_op[2]);
  end

  if (IN_REG) begin : g_in_reg
    logic               en, clr;
    logic [3:0][AW-1:0] a_q;
    logic [3:0][BW-1:0] b_q;
    logic [2:0]         c_q;
    assign en  = ce_src[IN_CE];
    assign clr = rst_src[IN_RST];
    always_ff @(posedge clk) begin
      if (clr) begin
        a_q <= '0;
        b_q <= '0;
        c_q <= '0;
      end else if (en) begin
        a_q <= a_nx;
        b_q <= b_nx;
        c_q <= c_in;
      end
    end
    assign a_op = a_q;
    assign b_op = b_q;
    assign c_op = c_q;
  end else begin : g_in_byp
    assign a_op = a_nx;
    assign b_op = b_nx;
    assign c_op = c_in;
  end

  assign a_sout = a_op[3];
  assign b_sout = b_op[3];

  if (PL_REG) begin : g_pl_reg
    logic               en, clr;
    logic [3:0][PW-1:0] p_q;
    logic [2:0]         c_q;
    assign en  = ce_src[PL_CE];
    assign clr = rst_src[PL_RST];
    always_ff @(posedge clk) begin
      if (clr) begin
        p_q <= '0;
        c_q <= '0;
      end else if (en) begin
        p_q <= p_nx;
        c_q <= c_op;
      end
    end
    assign p_op  = p_q;
    assign c2_op = c_q;
  end else begin : g_pl_byp
    assign p_op  = p_nx;
    assign c2_op = c_op;
  end

  assign s0 = pair(p_op[0], p_op[1], c2_op[2], c2_op[1]);
  assign s1 = pair(p_op[2], p_op[3], c2_op[2], c2_op[0]);
  assign sum_d = {(c2_op[2] | c2_op[1]) & s0[PW], s0}
               + {(c2_op[2] | c2_op[0]) & s1[PW], s1};

  if (OUT_REG) begin : g_out_reg
    logic          en, clr;
    logic [RW-1:0] r_q;
    assign en  = ce_src[OUT_CE];
    assign clr = rst_src[OUT_RST];
    always_ff @(posedge clk) begin
      if (clr)     r_q <= '0;
      else if (en) r_q <= sum_d;
    end
    assign result = r_q;
  end else begin : g_out_byp
    assign result = sum_d;
  end

endmodule

module quad_mac_sum_chk #(
  parameter int AW      = 9,
  parameter int BW      = 9,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  parameter int IN_CE   = 0,
  parameter int IN_RST  = 1,
  parameter int OUT_CE  = 2,
  parameter int OUT_RST = 3,
  localparam int RW = AW + BW + 2
) (
  input logic          clk,
  input logic [3:0]    ce_src,
  input logic [3:0]    rst_src,
  input logic          a_shift,
  input logic          b_shift,
  input logic [AW-1:0] a_sin,
  input logic [BW-1:0] b_sin,
  input logic [AW-1:0] a_sout,
  input logic [BW-1:0] b_sout,
  input logic [RW-1:0] result
);

  logic [2:0] age = 3'd0;
  logic       unused_chk;
  always_ff @(posedge clk) if (age != 3'd7) age <= age + 3'd1;
  assign unused_chk = ^{ce_src, rst_src};

  if (OUT_REG) begin : g_out
    // R5
    out_rst_clear_chk: assert property (@(posedge clk) disable iff (age == 3'd0)
      rst_src[OUT_RST] |=> (result == '0));
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (age == 3'd0)
      (!ce_src[OUT_CE] && !rst_src[OUT_RST]) |=> $stable(result));
  end

  if (IN_REG) begin : g_in
    logic adv_a, adv_b;
    assign adv_a = ce_src[IN_CE] && !rst_src[IN_RST] && a_shift;
    assign adv_b = ce_src[IN_CE] && !rst_src[IN_RST] && b_shift;
    // R8
    a_chain_chk: assert property (@(posedge clk) disable iff (age < 3'd5)
      ($past(adv_a, 1) && $past(adv_a, 2) && $past(adv_a, 3) && $past(adv_a, 4))
      |-> (a_sout == $past(a_sin, 4)));
    // R8
    b_chain_chk: assert property (@(posedge clk) disable iff (age < 3'd5)
      ($past(adv_b, 1) && $past(adv_b, 2) && $past(adv_b, 3) && $past(adv_b, 4))
      |-> (b_sout == $past(b_sin, 4)));
  end else begin : g_in_byp
    // R8
    a_chain_comb_chk: assert property (@(posedge clk) disable iff (age == 3'd0)
      a_shift |-> (a_sout == a_sin));
    // R8
    b_chain_comb_chk: assert property (@(posedge clk) disable iff (age == 3'd0)
      b_shift |-> (b_sout == b_sin));
  end

endmodule

bind quad_mac_sum quad_mac_sum_chk #(
  .AW(AW), .BW(BW), .IN_REG(IN_REG), .OUT_REG(OUT_REG),
  .IN_CE(IN_CE), .IN_RST(IN_RST), .OUT_CE(OUT_CE), .OUT_RST(OUT_RST)
) chk_i (
  .clk(clk), .ce_src(ce_src), .rst_src(rst_src), .a_shift(a_shift), .b_shift(b_shift),
  .a_sin(a_sin), .b_sin(b_sin), .a_sout(a_sout), .b_sout(b_sout), .result(result)
);

// File: tb/quad_mac_sum_tb_top.sv
`timescale 1ns/100ps
module quad_mac_sum_tb_top;
  localparam int AW = 9, BW = 9, RW = AW + BW + 2;

  logic            clk = 1'b0;
  logic [3:0]      ce_src = 4'hF, rst_src = 4'hF;
  logic            signed_mode = 0, sub0 = 0, sub1 = 0, a_shift = 0, b_shift = 0;
  logic [4*AW-1:0] a_bus = '0;
  logic [4*BW-1:0] b_bus = '0;
  logic [AW-1:0]   a_sin = '0, a_sout, ac_sout;
  logic [BW-1:0]   b_sin = '0, b_sout, bc_sout;
  logic [RW-1:0]   result, res_c;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [RW-1:0] exp_q [3];
  bit            vld_q [3];

  always #2.5 clk = ~clk;

  quad_mac_sum dut_i (.clk, .ce_src, .rst_src, .signed_mode, .sub0, .sub1, .a_shift, .b_shift,
    .a_bus, .b_bus, .a_sin, .b_sin, .a_sout, .b_sout, .result);

  quad_mac_sum #(.IN_REG(1'b0), .PL_REG(1'b0), .OUT_REG(1'b0)) comb_i (.clk, .ce_src, .rst_src,
    .signed_mode, .sub0, .sub1, .a_shift, .b_shift, .a_bus, .b_bus, .a_sin, .b_sin,
    .a_sout(ac_sout), .b_sout(bc_sout), .result(res_c));

  function automatic logic [RW-1:0] model(logic [4*AW-1:0] av, logic [4*BW-1:0] bv,
                                          bit sg, bit s0, bit s1);
    longint p [4];
    longint tot;
    for (int k = 0; k < 4; k++) begin
      longint x = longint'(av[k*AW +: AW]);
      longint y = longint'(bv[k*BW +: BW]);
      if (sg && av[k*AW+AW-1]) x = x - (longint'(1) << AW);
      if (sg && bv[k*BW+BW-1]) y = y - (longint'(1) << BW);
      p[k] = x * y;
    end
    tot = (s0 ? p[0] - p[1] : p[0] + p[1]) + (s1 ? p[2] - p[3] : p[2] + p[3]);
    return tot[RW-1:0];
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic flush_hist();
    for (int i = 0; i < 3; i++) vld_q[i] = 0;
  endtask

  task automatic step(input logic [4*AW-1:0] av, input logic [4*BW-1:0] bv,
                      input bit sg, input bit s0, input bit s1, input bit keep);
    logic [RW-1:0] m;
    if (vld_q[2]) check("R4 three-stage latency, R1 R2 R3 arithmetic", result, exp_q[2]);
    exp_q[2] = exp_q[1]; vld_q[2] = vld_q[1];
    exp_q[1] = exp_q[0]; vld_q[1] = vld_q[0];
    a_bus = av; b_bus = bv; signed_mode = sg; sub0 = s0; sub1 = s1;
    m = model(av, bv, sg, s0, s1);
    exp_q[0] = m; vld_q[0] = keep;
    #1;
    check(sg ? "R2 R4 zero-latency signed" : "R1 R4 zero-latency unsigned", res_c, m);
    @(negedge clk);
  endtask

  task automatic rnd_step(input bit keep);
    logic [4*AW-1:0] av;
    logic [4*BW-1:0] bv;
    av = {$urandom, $urandom};
    bv = {$urandom, $urandom};
    step(av, bv, 1'($urandom), 1'($urandom), 1'($urandom), keep);
  endtask

  initial begin
    logic [RW-1:0] held;
    logic [AW-1:0] sa [12];
    logic [BW-1:0] sb [12];
    void'($urandom(32'd20240611));
    flush_hist();
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 reset result", result, '0);
    check("R5 reset a_sout", RW'(a_sout), '0);
    check("R5 reset b_sout", RW'(b_sout), '0);
    rst_src = 4'h0;

    // R9 boundary, R2 signed minimum, R3 subtract combos
    step('1, '1, 0, 0, 0, 1);
    step({4{9'h100}}, {4{9'h100}}, 1, 0, 0, 1);
    step({4{9'h100}}, {4{9'h0FF}}, 1, 1, 1, 1);
    step('0, '1, 1, 1, 0, 1);
    step('1, '1, 0, 1, 1, 1);
    step({9'd3, 9'd5, 9'd7, 9'd2}, {9'd11, 9'd13, 9'd1, 9'd4}, 0, 1, 0, 1);
    step('1, '1, 1, 0, 1, 1);
    for (int i = 0; i < 300; i++) rnd_step(1);
    step('0, '0, 0, 0, 0, 1);
    step('0, '0, 0, 0, 0, 1);
    step('0, '0, 0, 0, 0, 1);
    check("R9 all-ones unsigned no wrap", model('1, '1, 0, 0, 0), RW'(4 * 511 * 511));

    // R7 unselected lines toggled, pipeline must keep matching
    for (int i = 0; i < 40; i++) begin
      ce_src[3]  = 1'($urandom);
      rst_src[0] = 1'($urandom);
      rnd_step(1);
    end
    ce_src[3] = 1'b1; rst_src[0] = 1'b0;

    // R6 output enable low holds
    ce_src[2] = 1'b0;
    held = result;
    flush_hist();
    for (int i = 0; i < 4; i++) begin
      rnd_step(0);
      check("R6 output held while enable low", result, held);
    end
    ce_src[2] = 1'b1;
    for (int i = 0; i < 5; i++) rnd_step(1);

    // R5 output reset wins over enable; bypassed copy ignores it (R7)
    rst_src[3] = 1'b1;
    flush_hist();
    rnd_step(0);
    rst_src[3] = 1'b0;
    check("R5 output reset clears", result, '0);
    for (int i = 0; i < 5; i++) rnd_step(1);

    // R5 operand stage reset on its line, then flows zero through
    rst_src[1] = 1'b1;
    flush_hist();
    rnd_step(0);
    rst_src[1] = 1'b0;
    rnd_step(0);
    rnd_step(0);
    check("R5 operand reset propagates zero", result, '0);
    for (int i = 0; i < 5; i++) rnd_step(1);

    // R8 shift chains
    flush_hist();
    a_shift = 1; b_shift = 1;
    for (int i = 0; i < 12; i++) begin
      if (i >= 4) begin
        check("R8 a chain delay", RW'(a_sout), RW'(sa[i-4]));
        check("R8 b chain delay", RW'(b_sout), RW'(sb[i-4]));
      end
      sa[i] = AW'($urandom); sb[i] = BW'($urandom);
      a_sin = sa[i]; b_sin = sb[i];
      #1;
      check("R8 bypassed a chain", RW'(ac_sout), RW'(sa[i]));
      check("R8 bypassed b chain", RW'(bc_sout), RW'(sb[i]));
      @(negedge clk);
    end
    // after 4 shifts lanes hold sa[11..8]; all-add unsigned
    signed_mode = 0; sub0 = 0; sub1 = 0;
    a_shift = 0; b_shift = 0;
    a_bus = {sa[8], sa[9], sa[10], sa[11]};
    b_bus = {sb[8], sb[9], sb[10], sb[11]};
    flush_hist();
    for (int i = 0; i < 10; i++) rnd_step(1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule